// File: doc/BRIEF.md
# Packed Lane Shift and Permute Unit

This unit is a 64-bit SIMD shifter. It splits one operand into lanes of 16, 32 or 64 bits and applies a logical right shift, logical left shift, arithmetic right shift or rotate right to every lane on its own. No bit crosses from one lane into the next. Two more operations share the same output path:

- A halfword shuffle, which rebuilds the word from four 16-bit source pieces picked by an 8-bit selector.
- A byte-align extract, which takes 64 bits at a byte offset out of a second operand stacked on top of the first.

A caller places the operands, count, lane size, operation code and selector on the inputs and raises `start_i` for one cycle. The result and a packed negative/zero flag word are registered at that clock edge. `done_o` pulses during the cycle that follows. Outputs hold their values between strobes.

Top module: `pshf_unit`

## Requirements
- R1: Logical right (op 0) and logical left (op 1) shift each lane by `cnt_i`. Bits that leave a lane are dropped, and vacated bits are zero. The lane code is 0 for 16-bit lanes, 1 for 32-bit lanes, and 2 or 3 for one 64-bit lane.
- R2: Arithmetic right shift (op 2) fills vacated bits of each lane with that lane's own top bit, for 16, 32 and 64-bit lanes.
- R3: Rotate right (op 3) feeds bits that leave the bottom of a lane back into the top of the same lane. The count is taken modulo the lane width.
- R4: A count equal to or larger than the lane width gives an all-zero lane for ops 0 and 1. For op 2 it gives a lane filled with copies of its sign bit.
- R5: Shuffle (op 4) writes 16-bit destination lane k, for k from 0 to 3, with source halfword `sel_i[2k+1:2k]` of `a_i`. The lane code and count are ignored.
- R6: Align (op 5) returns bits [8n+63:8n] of the 128-bit value {`b_i`,`a_i`}, where n = `cnt_i[2:0]`.
- R7: For ops 0 to 4, the flag word holds one N and one Z flag per lane. N is the lane's top bit and Z is set when the lane is all zero. Placement depends on the lane size, and op 4 always uses the 16-bit layout. Every other flag bit is zero.

  | Lane size | N bit | Z bit | Lanes |
  |-----------|-------|-------|-------|
  | 16-bit | 8h+7 | 8h+6 | h = 0 to 3 |
  | 32-bit | 16w+15 | 16w+14 | w = 0 to 1 |
  | 64-bit | 31 | 30 | one lane |
- R8: Align leaves `flags_o` unchanged.
- R9: `res_o` and `flags_o` change only at a clock edge where `start_i` is high. `done_o` is high during exactly the cycle after each such edge.
- R10: During and right after reset, `res_o`, `flags_o` and `done_o` are zero.
- R11: Op codes 6 and 7 leave `res_o` and `flags_o` unchanged, and `done_o` still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| lane_i | input | 2 | Lane size code |
| cnt_i | input | 7 | Shift/rotate count; low 3 bits give the align offset |
| a_i | input | 64 | Primary operand |
| b_i | input | 64 | Upper operand for align |
| sel_i | input | 8 | Shuffle selector |
| res_o | output | 64 | Registered result |
| flags_o | output | 32 | Registered packed N/Z flag word |
| done_o | output | 1 | Result-valid pulse |

## Verification
Every result and flag word is registered at the edge where `start_i` is high. The bench therefore raises the strobe on a falling edge and drops it on the next falling edge. At that same point, half a cycle after the capturing edge, it compares `res_o`, `flags_o` and `done_o` against its reference model. One cycle later it checks that `done_o` has fallen.

For align and the reserved codes, the expected flags (and, for reserved codes, the expected result) are the values the bench model kept from the previous operation. Idle-hold checks leave the strobe low for several cycles while the data inputs change, then compare the outputs against the last values.

// File: rtl/pshf_pkg.sv
package pshf_pkg;

  typedef enum logic [2:0] {
    OP_SRL   = 3'd0,
    OP_SLL   = 3'd1,
    OP_SRA   = 3'd2,
    OP_ROR   = 3'd3,
    OP_SHUF  = 3'd4,
    OP_ALIGN = 3'd5
  } pshf_op_e;

  typedef enum logic [1:0] {
    LN_16 = 2'd0,
    LN_32 = 2'd1,
    LN_64 = 2'd2
  } pshf_lane_e;

  localparam int unsigned MIN_LANE_W = 16;
  localparam int unsigned NUM_LSIZES = 3;

endpackage

// File: rtl/pshf_lane_shift.sv
module pshf_lane_shift
  import pshf_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned LW = 16,
  parameter int unsigned CW = 7
) (
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] cnt_i,
  input  pshf_op_e      op_i,
  output logic [DW-1:0] res_o
);
  localparam int unsigned NL = DW / LW;
  localparam int unsigned RW = $clog2(LW);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [LW-1:0] x;
    logic [LW-1:0] y;
    logic [RW-1:0] r;

    assign x = data_i[i*LW +: LW];
    assign r = cnt_i[RW-1:0];

    always_comb begin
      unique case (op_i)
        OP_SRL:  y = x >> cnt_i;
        OP_SLL:  y = x << cnt_i;
        OP_SRA:  y = $signed(x) >>> cnt_i;
        OP_ROR:  y = (x >> r) | (x << (LW - {{(32-RW){1'b0}}, r}));
        default: y = x;
      endcase
    end

    assign res_o[i*LW +: LW] = y;
  end
endmodule

// File: rtl/pshf_shuffle.sv
module pshf_shuffle #(
  parameter int unsigned DW = 64,
  parameter int unsigned HW = 16,
  localparam int unsigned NH = DW / HW,
  localparam int unsigned SW = $clog2(NH)
) (
  input  logic [DW-1:0]    data_i,
  input  logic [NH*SW-1:0] sel_i,
  output logic [DW-1:0]    res_o
);
  for (genvar k = 0; k < NH; k++) begin : g_dst
    logic [SW-1:0] idx;
    assign idx = sel_i[k*SW +: SW];
    assign res_o[k*HW +: HW] = data_i[idx*HW +: HW];
  end
endmodule

// File: rtl/pshf_align.sv
module pshf_align #(
  parameter int unsigned DW = 64,
  localparam int unsigned NB = DW / 8,
  localparam int unsigned OW = $clog2(NB)
) (
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [OW-1:0] ofs_i,
  output logic [DW-1:0] res_o
);
  logic [2*DW-1:0] wide;

  assign wide  = {hi_i, lo_i} >> {ofs_i, 3'b000};
  assign res_o = wide[DW-1:0];
endmodule

// File: rtl/pshf_flags.sv
module pshf_flags
  import pshf_pkg::*;
#(
  parameter int unsigned DW = 64,
  localparam int unsigned FW = DW / 2
) (
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    lane_i,
  output logic [FW-1:0] flags_o
);
  logic [NUM_LSIZES-1:0][FW-1:0] fw;

  for (genvar g = 0; g < NUM_LSIZES; g++) begin : g_size
    localparam int unsigned LW = MIN_LANE_W << g;
    localparam int unsigned NL = DW / LW;
    localparam int unsigned SP = LW / 2;
    logic [FW-1:0] f;

    always_comb begin
      f = '0;
      for (int i = 0; i < NL; i++) begin
        f[SP*(i+1)-1] = data_i[i*LW + LW - 1];
        f[SP*(i+1)-2] = ~|data_i[i*LW +: LW];
      end
    end

    assign fw[g] = f;
  end

  always_comb begin
    unique case (lane_i)
      2'd0:    flags_o = fw[0];
      2'd1:    flags_o = fw[1];
      default: flags_o = fw[2];
    endcase
  end
endmodule

// File: rtl/pshf_unit.sv
module pshf_unit
  import pshf_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned CW = 7,
  localparam int unsigned FW = DW / 2,
  localparam int unsigned SLW = 2 * ((DW / 16) > 1 ? $clog2(DW / 16) : 1) * (DW / 16) / 2,
  localparam int unsigned OW = $clog2(DW / 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    lane_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [SLW-1:0] sel_i,
  output logic [DW-1:0] res_o,
  output logic [FW-1:0] flags_o,
  output logic          done_o
);
  pshf_op_e op;
  assign op = pshf_op_e'(op_i);

  // Lane shifters, one per supported lane width
  logic [NUM_LSIZES-1:0][DW-1:0] shv;

  for (genvar g = 0; g < NUM_LSIZES; g++) begin : g_shift
    pshf_lane_shift #(
      .DW(DW),
      .LW(MIN_LANE_W << g),
      .CW(CW)
    ) u_sh (
      .data_i(a_i),
      .cnt_i (cnt_i),
      .op_i  (op),
      .res_o (shv[g])
    );
  end

  logic [DW-1:0] sh_sel;
  always_comb begin
    unique case (lane_i)
      2'd0:    sh_sel = shv[0];
      2'd1:    sh_sel = shv[1];
      default: sh_sel = shv[2];
    endcase
  end

  logic [DW-1:0] shuf_res;
  pshf_shuffle #(.DW(DW), .HW(16)) u_shuf (
    .data_i(a_i),
    .sel_i (sel_i),
    .res_o (shuf_res)
  );

  logic [DW-1:0] algn_res;
  pshf_align #(.DW(DW)) u_algn (
    .lo_i (a_i),
    .hi_i (b_i),
    .ofs_i(cnt_i[OW-1:0]),
    .res_o(algn_res)
  );

  // Next-state selection
  logic [DW-1:0] res_d;
  logic          res_upd;
  logic          flg_upd;
  logic [1:0]    flg_lane;

  always_comb begin
    res_d    = res_o;
    res_upd  = 1'b1;
    flg_upd  = 1'b1;
    flg_lane = lane_i;
    unique case (op)
      OP_SRL, OP_SLL, OP_SRA, OP_ROR: res_d = sh_sel;
      OP_SHUF: begin
        res_d    = shuf_res;
        flg_lane = 2'd0;
      end
      OP_ALIGN: begin
        res_d   = algn_res;
        flg_upd = 1'b0;
      end
      default: begin
        res_upd = 1'b0;
        flg_upd = 1'b0;
      end
    endcase
  end

  logic [FW-1:0] flags_d;
  pshf_flags #(.DW(DW)) u_flg (
    .data_i (res_d),
    .lane_i (flg_lane),
    .flags_o(flags_d)
  );

  logic res_en;
  logic flg_en;
  assign res_en = start_i & res_upd;
  assign flg_en = start_i & flg_upd;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      flags_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= start_i;
      if (res_en) res_o   <= res_d;
      if (flg_en) flags_o <= flags_d;
    end
  end
endmodule

// File: rtl/pshf_unit_chk.sv
module pshf_unit_chk #(
  parameter int unsigned DW = 64,
  parameter int unsigned CW = 7,
  localparam int unsigned FW = DW / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [2:0]    op_i,
  input logic [1:0]    lane_i,
  input logic [CW-1:0] cnt_i,
  input logic [DW-1:0] res_o,
  input logic [FW-1:0] flags_o,
  input logic          done_o
);
  function automatic logic [FW-1:0] free_bits();
    logic [FW-1:0] m;
    m = '1;
    for (int i = 0; i < FW / 8; i++) begin
      m[8*i+7] = 1'b0;
      m[8*i+6] = 1'b0;
    end
    return m;
  endfunction

  localparam logic [FW-1:0] FREE_MASK = free_bits();

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);  // R9
  AST_DONE_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(res_o) && $stable(flags_o));  // R9
  AST_ALIGN_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == 3'd5) |=> $stable(flags_o));  // R8
  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i[2:1] == 2'b11) |=> $stable(res_o) && $stable(flags_o));  // R11
  AST_FLAG_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & FREE_MASK) == '0);  // R7
  AST_OVERSIZE_SRL16: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == 3'd0 && lane_i == 2'd0 && cnt_i >= CW'(16)) |=> res_o == '0);  // R4
endmodule

bind pshf_unit pshf_unit_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .op_i   (op_i),
  .lane_i (lane_i),
  .cnt_i  (cnt_i),
  .res_o  (res_o),
  .flags_o(flags_o),
  .done_o (done_o)
);

// File: tb/sim_pshf_unit.sv
`timescale 1ns/1ps
module sim_pshf_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  op_i;
  logic [1:0]  lane_i;
  logic [6:0]  cnt_i;
  logic [63:0] a_i, b_i;
  logic [7:0]  sel_i;
  logic [63:0] res_o;
  logic [31:0] flags_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [63:0] m_res;
  logic [31:0] m_flg;

  always #4 clk = ~clk;

  pshf_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .lane_i(lane_i),
    .cnt_i(cnt_i), .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
    .res_o(res_o), .flags_o(flags_o), .done_o(done_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lw_of(int lane);
    return (lane == 0) ? 16 : (lane == 1) ? 32 : 64;
  endfunction

  function automatic logic [63:0] lmask(int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] ref_shift(int op, int w, int c, logic [63:0] a);
    logic [63:0] res, m, x, y;
    logic sgn;
    int r;
    res = '0;
    m = lmask(w);
    for (int i = 0; i < 64 / w; i++) begin
      x = (a >> (i * w)) & m;
      sgn = x[w-1];
      r = c % w;
      case (op)
        0: y = (c >= w) ? 64'd0 : (x >> c);
        1: y = (c >= w) ? 64'd0 : ((x << c) & m);
        2: begin
          if (c >= w) y = sgn ? m : 64'd0;
          else y = (x >> c) | (sgn ? (m & ~(m >> c)) : 64'd0);
        end
        default: y = (r == 0) ? x : (((x >> r) | (x << (w - r))) & m);
      endcase
      res |= y << (i * w);
    end
    return res;
  endfunction

  function automatic logic [31:0] ref_flags(int w, logic [63:0] v);
    logic [31:0] f;
    logic [63:0] x;
    f = '0;
    for (int i = 0; i < 64 / w; i++) begin
      x = (v >> (i * w)) & lmask(w);
      f[(w/2)*(i+1)-1] = x[w-1];
      f[(w/2)*(i+1)-2] = (x == 64'd0);
    end
    return f;
  endfunction

  function automatic logic [63:0] ref_shuf(logic [63:0] a, logic [7:0] s);
    logic [63:0] res;
    int idx;
    res = '0;
    for (int k = 0; k < 4; k++) begin
      idx = (s >> (2 * k)) & 3;
      res |= ((a >> (16 * idx)) & 64'hFFFF) << (16 * k);
    end
    return res;
  endfunction

  function automatic logic [63:0] ref_align(logic [63:0] a, logic [63:0] b, int n);
    if (n == 0) return a;
    return (a >> (8 * n)) | (b << (64 - 8 * n));
  endfunction

  task automatic run_op(int op, int lane, int cnt, logic [63:0] a, logic [63:0] b, logic [7:0] s);
    logic [63:0] er;
    logic [31:0] ef;
    string rq;
    int w;
    w = lw_of(lane);
    er = m_res;
    ef = m_flg;
    case (op)
      0, 1: begin er = ref_shift(op, w, cnt, a); ef = ref_flags(w, er); rq = (cnt >= w) ? "R4" : "R1"; end
      2: begin er = ref_shift(op, w, cnt, a); ef = ref_flags(w, er); rq = (cnt >= w) ? "R4" : "R2"; end
      3: begin er = ref_shift(op, w, cnt, a); ef = ref_flags(w, er); rq = "R3"; end
      4: begin er = ref_shuf(a, s); ef = ref_flags(16, er); rq = "R5"; end
      5: begin er = ref_align(a, b, cnt % 8); rq = "R6"; end
      default: rq = "R11";
    endcase
    @(negedge clk);
    op_i = 3'(op); lane_i = 2'(lane); cnt_i = 7'(cnt);
    a_i = a; b_i = b; sel_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(rq, res_o, er);
    if (op == 5) chk("R8 flags", {32'd0, flags_o}, {32'd0, ef});
    else if (op >= 6) chk("R11 flags", {32'd0, flags_o}, {32'd0, ef});
    else chk("R7 flags", {32'd0, flags_o}, {32'd0, ef});
    chk("R9 done", {63'd0, done_o}, 64'd1);
    m_res = er;
    m_flg = ef;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; lane_i = '0; cnt_i = '0;
    a_i = '0; b_i = '0; sel_i = '0;
    m_res = '0; m_flg = '0;
    repeat (3) @(negedge clk);
    chk("R10 res", res_o, 64'd0);
    chk("R10 flags", {32'd0, flags_o}, 64'd0);
    chk("R10 done", {63'd0, done_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", res_o, 64'd0);

    // Directed corners
    run_op(0, 0, 1, 64'h8001_8001_8001_8001, 0, 0);          // R1 no leak right
    run_op(1, 0, 1, 64'h8001_8001_8001_8001, 0, 0);          // R1 no leak left
    run_op(1, 1, 4, 64'hF000_0001_0FFF_FFFF, 0, 0);          // R1 32-bit
    run_op(2, 1, 4, 64'h8000_0000_7000_0000, 0, 0);          // R2
    run_op(2, 2, 63, 64'h8000_0000_0000_0000, 0, 0);         // R2 64-bit
    run_op(2, 1, 40, 64'h8000_0000_7FFF_FFFF, 0, 0);         // R4 sign fill
    run_op(0, 0, 16, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);         // R4 zero
    run_op(1, 2, 64, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);         // R4 zero 64
    run_op(3, 0, 17, 64'h0001_0003_8000_1234, 0, 0);         // R3 mod 16
    run_op(3, 1, 32, 64'h1234_5678_9ABC_DEF0, 0, 0);         // R3 mod 32
    run_op(3, 2, 4, 64'h0000_0000_0000_000F, 0, 0);          // R3 64
    run_op(4, 2, 5, 64'h4444_3333_2222_1111, 0, 8'h1B);      // R5 reverse
    run_op(4, 1, 0, 64'h0000_8000_0000_0001, 0, 8'h00);      // R5 broadcast
    run_op(1, 0, 0, 64'h0000_8000_0000_1234, 0, 0);          // flags set before align
    run_op(5, 0, 0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0); // R6 n=0, R8
    run_op(5, 2, 7, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0); // R6 n=7, R8
    run_op(5, 0, 11, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0); // R6 n=3
    run_op(6, 0, 3, 64'hDEAD_BEEF_0000_0000, 0, 0);          // R11
    run_op(7, 1, 9, 64'h1111_1111_1111_1111, 0, 0);          // R11

    // R9: done falls, idle hold while inputs move
    @(negedge clk);
    chk("R9 done low", {63'd0, done_o}, 64'd0);
    for (int j = 0; j < 4; j++) begin
      a_i = {$urandom, $urandom}; op_i = 3'($urandom); cnt_i = 7'($urandom);
      @(negedge clk);
      chk("R9 idle res", res_o, m_res);
      chk("R9 idle flags", {32'd0, flags_o}, {32'd0, m_flg});
    end

    // Random mix
    for (int j = 0; j < 400; j++) begin
      int op, ln, ct;
      op = $urandom % 8;
      ln = $urandom % 4;
      ct = ($urandom % 4 == 0) ? ($urandom % 128) : ($urandom % (lw_of(ln) + 1));
      run_op(op, ln, ct, {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule